// File: doc/BRIEF.md
# NAND Address Cycle Generator

This block turns a 64-bit linear flash address into the bytes a NAND controller drives during the address-latch phase of a command. The linear address is read as three packed fields. The column (the byte offset in the page) sits at the bottom, the page inside its block sits next, and the block number fills the bits above. The split points come from two configuration inputs: log2 of the page size and log2 of the pages per block.

The column is padded to a whole number of bytes. It takes two bytes for pages of 512 B up to 64 KB, and three bytes for pages of 128 KB up to 16 MB. The row address is the page field with the block field packed directly above it, cut to the configured number of row cycles. There is no separate address for the out-of-band area. A transfer that runs past the last page byte simply continues into it, so a column value never names a spare byte.

When a start strobe is accepted, the block captures the address and the configuration. It publishes the total address-byte count, which a command word can carry, and then streams the bytes over a valid/ready handshake, least significant byte first: all column bytes, then all row bytes. It pulses done after the last byte is taken. A configuration it cannot serve raises a one-cycle error and produces no bytes.

Top module: `nas_addr_seq`

## Requirements
- R1: A page_log2 from 9 to 16 gives 2 column bytes, and a page_log2 from 17 to 24 gives 3 column bytes.
- R2: The column bytes carry addr bits below page_log2, zero-padded up to the column byte width. Address bits at or above page_log2 never appear in the column bytes.
- R3: The row value is addr shifted right by page_log2, formed as the page field (ppb_log2 bits) with the block field directly above it. It is truncated to row_cycles bytes.
- R4: Bytes are emitted least significant first: every column byte, then every row byte.
- R5: In the cycle after an accepted start, byte_count equals column bytes plus row_cycles. It holds that value until the next accepted start.
- R6: If page_log2 is below 9 or above 24, row_cycles is 0, or the total exceeds 8, then err is high for exactly the cycle after the start, and ab_valid and busy stay low.
- R7: While ab_valid is high and ab_ready is low, ab_data and ab_valid hold. One byte advances per cycle in which both are high.
- R8: done is high for exactly one cycle, the cycle after the last byte is accepted. In that same cycle busy and ab_valid are already low.
- R9: A start while busy is high, including in the cycle of the final handshake, is ignored. The stream and byte_count are unchanged, and no new sequence follows.
- R10: After reset, ab_valid, done, err and busy are 0, and byte_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a sequence; taken only when idle |
| addr | input | 64 | Linear flash address |
| page_log2 | input | 5 | log2 of page size in bytes |
| ppb_log2 | input | 3 | log2 of pages per block |
| row_cycles | input | 3 | Number of row address bytes |
| ab_ready | input | 1 | Consumer accepts the current byte |
| ab_valid | output | 1 | ab_data holds an address byte |
| ab_data | output | 8 | Current address byte |
| byte_count | output | 4 | Total address bytes of the last accepted start |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse after the final byte |
| err | output | 1 | One-cycle pulse for a rejected configuration |

## Verification
Two events can land in the same cycle: the final handshake of a sequence and a fresh start strobe. The bench raises start exactly in that cycle, and also halfway through a stream. Each time it uses a different address and row count. It expects done to pulse, byte_count to keep the old total, and ab_valid to stay low afterwards. The reference model holds the expected bytes in a queue and compares ab_valid, ab_data and done against it on every clock, under both continuous and stalled ready patterns.

// File: rtl/nas_pkg.sv
// Package: shared widths and configuration limits for the address cycle generator.
// Assumes byte-wide address cycles and a linear address of at most 64 bits.
package nas_pkg;
    localparam int BYTE_W    = 8;
    localparam int PL_W      = 5;   // width of page_log2
    localparam int PB_W      = 3;   // width of ppb_log2
    localparam int RC_W      = 3;   // width of row_cycles
    localparam int CB_W      = 2;   // width of column byte count
    localparam int MIN_PL    = 9;   // 512 B pages
    localparam int MID_PL    = 16;  // last page size needing two column bytes
    localparam int MAX_PL    = 24;  // 16 MB pages
endpackage

// File: rtl/nas_cfg_decode.sv
// Module: decodes page size and row cycle count into the column byte count,
// the total address byte count, and a reject flag. Purely combinational.
// Assumes page_log2 and row_cycles are stable while start is presented.
module nas_cfg_decode
    import nas_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int MAX_BYTES = 8
) (
    input  logic [PL_W-1:0]  page_log2,
    input  logic [RC_W-1:0]  row_cycles,
    output logic [CB_W-1:0]  col_bytes,
    output logic [CNT_W-1:0] total,
    output logic             bad
);
    // Column width by page size, total count and configuration check.
    always_comb begin
        col_bytes = (int'(page_log2) <= MID_PL) ? CB_W'(2) : CB_W'(3);
        total     = CNT_W'(col_bytes) + CNT_W'(row_cycles);
        bad       = (int'(page_log2) < MIN_PL) || (int'(page_log2) > MAX_PL) ||
                    (row_cycles == '0) || (int'(total) > MAX_BYTES);
    end
endmodule

// File: rtl/nas_field_pack.sv
// Module: splits the linear address into column, page and block fields and
// packs them into one little-endian byte vector: column bytes, then row bytes.
// Assumes col_bytes * 8 + row_cycles * 8 does not exceed ADDR_W (checked upstream).
module nas_field_pack
    import nas_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PL_W-1:0]   page_log2,
    input  logic [PB_W-1:0]   ppb_log2,
    input  logic [RC_W-1:0]   row_cycles,
    input  logic [CB_W-1:0]   col_bytes,
    output logic [ADDR_W-1:0] packed_bytes
);
    localparam logic [ADDR_W-1:0] ONES = '1;

    logic [ADDR_W-1:0] col_f, above, page_f, block_f, row_f, row_mask;

    // Field extraction and repacking of the row directly above the padded column.
    always_comb begin
        col_f        = addr & ~(ONES << page_log2);
        above        = addr >> page_log2;
        page_f       = above & ~(ONES << ppb_log2);
        block_f      = above >> ppb_log2;
        row_f        = (block_f << ppb_log2) | page_f;
        row_mask     = ~(ONES << {row_cycles, 3'b000});
        packed_bytes = col_f | ((row_f & row_mask) << {col_bytes, 3'b000});
    end
endmodule

// File: rtl/nas_byte_shifter.sv
// Module: holds the packed address bytes and releases them one per valid/ready
// handshake, least significant first. Flags the handshake of the final byte.
// Assumes load only arrives while idle.
module nas_byte_shifter
    import nas_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_data,
    input  logic [CNT_W-1:0]  load_count,
    input  logic              ready,
    output logic              valid,
    output logic [BYTE_W-1:0] data,
    output logic              last_ack
);
    logic [ADDR_W-1:0] shreg;
    logic [CNT_W-1:0]  remaining;

    // Output byte and handshake qualifiers.
    always_comb begin
        valid    = (remaining != '0);
        data     = shreg[BYTE_W-1:0];
        last_ack = valid && ready && (remaining == CNT_W'(1));
    end

    // Shift register and remaining-byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            remaining <= '0;
        end else if (load) begin
            shreg     <= load_data;
            remaining <= load_count;
        end else if (valid && ready) begin
            shreg     <= shreg >> BYTE_W;
            remaining <= remaining - CNT_W'(1);
        end
    end
endmodule

// File: rtl/nas_addr_seq.sv
// Module: top of the NAND address cycle generator. Accepts a start while idle,
// decodes the configuration, packs the address and streams the bytes.
// Assumes ab_ready follows valid/ready rules and that inputs are synchronous to clk.
module nas_addr_seq
    import nas_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int CNT_W     = 4,
    parameter int MAX_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PL_W-1:0]   page_log2,
    input  logic [PB_W-1:0]   ppb_log2,
    input  logic [RC_W-1:0]   row_cycles,
    input  logic              ab_ready,
    output logic              ab_valid,
    output logic [BYTE_W-1:0] ab_data,
    output logic [CNT_W-1:0]  byte_count,
    output logic              busy,
    output logic              done,
    output logic              err
);
    logic [CB_W-1:0]   col_bytes;
    logic [CNT_W-1:0]  total;
    logic              bad;
    logic [ADDR_W-1:0] packed_bytes;
    logic              accept, load, last_ack;

    nas_cfg_decode #(.CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)) dec_i (
        .page_log2 (page_log2),
        .row_cycles(row_cycles),
        .col_bytes (col_bytes),
        .total     (total),
        .bad       (bad)
    );

    nas_field_pack #(.ADDR_W(ADDR_W)) pack_i (
        .addr        (addr),
        .page_log2   (page_log2),
        .ppb_log2    (ppb_log2),
        .row_cycles  (row_cycles),
        .col_bytes   (col_bytes),
        .packed_bytes(packed_bytes)
    );

    nas_byte_shifter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (packed_bytes),
        .load_count(total),
        .ready     (ab_ready),
        .valid     (ab_valid),
        .data      (ab_data),
        .last_ack  (last_ack)
    );

    // Start acceptance: only while no sequence is running.
    always_comb begin
        busy   = ab_valid;
        accept = start && !busy;
        load   = accept && !bad;
    end

    // Registered count, error pulse and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_count <= '0;
            err        <= 1'b0;
            done       <= 1'b0;
        end else begin
            if (accept) byte_count <= total;
            err  <= accept && bad;
            done <= last_ack;
        end
    end
endmodule

// File: rtl/nas_addr_seq_checker.sv
// Module: protocol checker for nas_addr_seq, attached by bind.
// Assumes the same clock and synchronous active-low reset as the design.
module nas_addr_seq_checker #(
    parameter int CNT_W     = 4,
    parameter int MAX_BYTES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             ab_ready,
    input logic             ab_valid,
    input logic [7:0]       ab_data,
    input logic [CNT_W-1:0] byte_count,
    input logic             busy,
    input logic             done,
    input logic             err
);
    p_hold_on_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ab_valid && !ab_ready |=> ab_valid && $stable(ab_data));

    p_err_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !ab_valid && !busy);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ab_valid && ab_ready) && !ab_valid && !busy);

    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(byte_count));

    p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(byte_count) >= 3) && (int'(byte_count) <= MAX_BYTES));
endmodule

bind nas_addr_seq nas_addr_seq_checker #(.CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ab_ready  (ab_ready),
    .ab_valid  (ab_valid),
    .ab_data   (ab_data),
    .byte_count(byte_count),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/nas_addr_seq_tb.sv
// Bench: behavioural queue model of the address byte stream, compared every clock.
module nas_addr_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] addr = '0;
    logic [4:0]  page_log2 = 5'd11;
    logic [2:0]  ppb_log2 = 3'd6;
    logic [2:0]  row_cycles = 3'd3;
    logic        ab_ready = 1'b0;
    logic        ab_valid;
    logic [7:0]  ab_data;
    logic [3:0]  byte_count;
    logic        busy, done, err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    nas_addr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
        .page_log2(page_log2), .ppb_log2(ppb_log2), .row_cycles(row_cycles),
        .ab_ready(ab_ready), .ab_valid(ab_valid), .ab_data(ab_data),
        .byte_count(byte_count), .busy(busy), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Runs one sequence. stall: ready low every third cycle. mid_start: strobe
    // during the stream. end_start: strobe in the cycle of the final handshake.
    task automatic run(input logic [63:0] a, input int pl, input int pb, input int rc,
                       input bit stall, input bit mid_start, input bit end_start);
        byte q[$];
        int cb, total, cyc;
        bit bad;
        logic [63:0] col, row;
        cb    = (pl <= 16) ? 2 : 3;
        total = cb + rc;
        bad   = (pl < 9) || (pl > 24) || (rc == 0) || (total > 8);
        col   = a & ((64'd1 << pl) - 64'd1);
        row   = a >> pl;
        for (int i = 0; i < cb; i++) q.push_back(byte'(col >> (8 * i)));
        for (int j = 0; j < rc; j++) q.push_back(byte'(row >> (8 * j)));

        @(negedge clk);
        addr = a; page_log2 = 5'(pl); ppb_log2 = 3'(pb); row_cycles = 3'(rc);
        start = 1'b1; ab_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(int'(byte_count) == (total & 15), "R5 byte_count", byte_count, total);
        chk(err == bad, "R6 err pulse", err, bad);
        if (bad) begin
            chk(!ab_valid && !busy, "R6 no stream on error", ab_valid, 0);
            @(negedge clk);
            chk(!err && !ab_valid, "R6 err one cycle", err, 0);
            return;
        end
        cyc = 0;
        while (q.size() > 0) begin
            chk(ab_valid, "R7 valid while bytes remain", ab_valid, 1);
            chk(ab_data == q[0], "R4 byte order/value", ab_data, q[0]);
            chk(!done, "R8 no early done", done, 0);
            ab_ready = !(stall && (cyc % 3 == 1));
            if (mid_start && cyc == 1) begin
                start = 1'b1; addr = ~a; row_cycles = 3'(rc == 3 ? 4 : 3);
            end
            if (end_start && q.size() == 1 && ab_ready) begin
                start = 1'b1; addr = ~a; row_cycles = 3'(rc == 3 ? 4 : 3);
            end
            @(negedge clk);
            if (ab_ready) void'(q.pop_front());
            start = 1'b0;
            cyc++;
            if (cyc > 64) break;
        end
        ab_ready = 1'b0;
        chk(done, "R8 done after last byte", done, 1);
        chk(!ab_valid && !busy, "R8 idle with done", {ab_valid, busy}, 0);
        @(negedge clk);
        chk(!done, "R8 done single cycle", done, 0);
        chk(!ab_valid && !busy, "R9 no sequence from ignored start", ab_valid, 0);
        chk(int'(byte_count) == total, "R9 byte_count kept", byte_count, total);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!ab_valid && !done && !err && !busy && byte_count == 0, "R10 reset state",
            {ab_valid, done, err, busy, byte_count}, 0);
        rst_n = 1'b1;
        // R1 R2 R3: 2 KB page, column 0x7FF, page 0x2A, block 0x155
        run({45'd0, 10'h155, 6'h2A, 11'h7FF} | 64'h0, 11, 6, 3, 0, 0, 0);
        // R7: stalled ready, 4 KB page
        run(64'h0000_0012_3456_789A, 12, 6, 3, 1, 0, 0);
        // R1: 128 KB page needs 3 column bytes, total 8 boundary
        run(64'h00FE_DCBA_9876_5432, 17, 6, 5, 0, 0, 0);
        // R1 boundary: 64 KB page, still 2 column bytes
        run(64'hFFFF_FFFF_ABCD_1234, 16, 5, 2, 1, 0, 0);
        // R2: 512 B page, bit 8 in second column byte, rest of addr in row
        run(64'h0000_0000_0BAD_F1FF, 9, 5, 4, 0, 0, 0);
        // R1 upper boundary: 16 MB page
        run(64'h1122_3344_5566_7788, 24, 6, 5, 0, 0, 0);
        // R6: rejected configurations
        run(64'h1234, 17, 6, 6, 0, 0, 0);
        run(64'h1234, 8, 6, 3, 0, 0, 0);
        run(64'h1234, 25, 6, 3, 0, 0, 0);
        run(64'h1234, 12, 6, 0, 0, 0, 0);
        // R9: start mid-stream and start in the final handshake cycle
        run(64'h0000_0003_C0DE_0F0F, 11, 6, 3, 1, 1, 0);
        run(64'h0000_0007_BEEF_0A0A, 12, 6, 3, 0, 0, 1);
        // recovery after error and ignored starts
        run(64'h0000_0000_0001_0002, 10, 5, 3, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule